// File: doc/BRIEF.md
# Static-Run Auto-Mute Detector

This block watches the PCM sample stream of each audio channel and asks for that channel to be muted once the channel has carried silence for a long stretch. Silence means one value repeated without a break, either all zeros or all ones (the two's-complement value -1). A frame strobe marks each new sample. The block keeps one run counter per channel. When the counter reaches the run length, the channel's mute request rises. The first sample that is not silent clears the request. The block does not attenuate anything: the downstream volume stage acts on the request. A per-channel indicator pin follows the request so that external analog muting can be driven from it.

A linking input couples the channels. With it set, a mute on any channel mutes every channel. A detector enable lets the function be switched off. With the enable low, every request is withdrawn at once and every run is forgotten. The sample width, the channel count, the run length, whether all-ones counts as silence, and the indicator polarity are all parameters. With the default parameters the block has two 24-bit channels, a run of 8192 samples and active-low indicators.

Top module: `static_run_mute`

## Requirements
- R1: While reset is asserted and just after it is released, every mute request is 0 and every indicator pin is inactive (1 with the default active-low polarity).
- R2: A channel's mute request rises on the clock edge that accepts, through a frame strobe, the RUN_LEN-th consecutive silent sample of one value. A silent sample is all zeros or all ones. The request is still 0 after RUN_LEN-1 such samples.
- R3: A strobed sample that is neither all zeros nor all ones clears that channel's run on that edge, and the request drops on the same edge.
- R4: A strobed silent sample whose value differs from the run in progress (all zeros after all ones, or the reverse) restarts the run at 1. RUN_LEN further samples of the new value, counting that one, are then needed.
- R5: The run counter saturates at RUN_LEN. The request stays high for any number of further identical silent samples.
- R6: With link_mutes low, each channel is detected and muted on its own. Channel 0 uses smp_bus bits [SAMPLE_W-1:0] and drives mute_req[0]; channel 1 uses the next SAMPLE_W bits and drives mute_req[1].
- R7: With link_mutes high, every mute_req bit is high whenever any channel has completed a run. The link takes effect in the same cycle.
- R8: mute_ind[i] is active exactly when mute_req[i] is high. The pin is active low by default.
- R9: With det_en low, every request is 0 in the same cycle and all runs are cleared at the next edge. After det_en is raised again, a full run of RUN_LEN samples is needed.
- R10: Sample values on cycles without frame_stb are ignored, so runs and requests keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_en | input | 1 | Detector enable |
| link_mutes | input | 1 | Mute all channels when any one is silent |
| frame_stb | input | 1 | Qualifies the samples on smp_bus for one cycle |
| smp_bus | input | NUM_CH*SAMPLE_W | Signed samples, channel 0 in the low bits |
| mute_req | output | NUM_CH | Per-channel mute request to the volume stage |
| mute_ind | output | NUM_CH | Per-channel mute indicator pin |

## Verification
A strobed sample changes the run counter at the next rising edge. The counter drives mute_req and mute_ind through logic only, so a request caused by a sample is due one edge after that sample is driven. The bench drives each sample at a falling edge and compares the outputs at the following falling edge, which falls within that same cycle. Changes of det_en and link_mutes reach the outputs without any register. The bench therefore checks those one half-cycle after the change, before any further strobe, which keeps the combinational path apart from the counter path. The exact RUN_LEN-1 and RUN_LEN boundaries are checked directly. Random runs of mixed lengths are compared cycle by cycle against a reference model kept in the bench.

// File: rtl/amute_pkg.sv
package amute_pkg;

   // Which silent value a run is made of
   typedef enum logic {
      LVL_ZERO = 1'b0,
      LVL_ONES = 1'b1
   } static_lvl_e;

   // Result of classifying one sample
   typedef struct packed {
      logic        is_static;
      static_lvl_e lvl;
   } smp_class_t;

endpackage

// File: rtl/amute_classify.sv
module amute_classify
   import amute_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter bit DETECT_ONES = 1'b1
) (
   input  logic [SAMPLE_W-1:0] smp,
   output smp_class_t          cls
);

   logic all_zero;
   logic all_ones;

   assign all_zero = (smp == '0);

   // Variant: treat -1 as silence too, or only zero
   if (DETECT_ONES) begin : g_zero_and_ones
      assign all_ones = &smp;
   end else begin : g_zero_only
      assign all_ones = 1'b0;
   end

   always_comb begin
      cls.is_static = all_zero | all_ones;
      cls.lvl       = all_ones ? LVL_ONES : LVL_ZERO;
   end

   // A sample reported as a ones-run must really be all ones (R2)
   always_comb begin
      if (cls.is_static && cls.lvl == LVL_ONES) begin
         p_ones_class_r2: assert (smp == {SAMPLE_W{1'b1}});
      end
   end

endmodule

// File: rtl/amute_run_cnt.sv
module amute_run_cnt
   import amute_pkg::*;
#(
   parameter int RUN_LEN = 8192
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       stb,
   input  smp_class_t cls,
   output logic       run_hit
);

   localparam int               CNT_W   = $clog2(RUN_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   static_lvl_e      last;
   logic             same_lvl;

   assign same_lvl = (cls.lvl == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         last <= LVL_ZERO;
      end else if (!en) begin
         cnt  <= '0;
         last <= LVL_ZERO;
      end else if (stb) begin
         if (!cls.is_static) begin
            cnt <= '0;
         end else if (cnt != '0 && !same_lvl) begin
            cnt  <= CNT_ONE;
            last <= cls.lvl;
         end else begin
            last <= cls.lvl;
            if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
         end
      end
   end

   assign run_hit = (cnt == CNT_MAX);

   p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX);
   p_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && stb && cls.is_static && same_lvl && run_hit) |=> run_hit);
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && stb && !cls.is_static) |=> (cnt == '0));
   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && stb && cls.is_static && cnt != '0 && !same_lvl) |=> (cnt == CNT_ONE));
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !stb) |=> $stable(cnt));
   p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));
   p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_hit) |-> $past(en && stb && cls.is_static));

endmodule

// File: rtl/amute_link.sv
module amute_link #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              link,
   input  logic [NUM_CH-1:0] hit,
   output logic [NUM_CH-1:0] req
);

   logic any_hit;

   assign any_hit = |hit;

   always_comb begin
      if (!en)       req = '0;
      else if (link) req = {NUM_CH{any_hit}};
      else           req = hit;
   end

   p_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && link) |-> (req == '0 || req == {NUM_CH{1'b1}}));
   p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (req == '0));
   p_indep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !link) |-> ((req & ~hit) == '0));

endmodule

// File: rtl/amute_ind.sv
module amute_ind #(
   parameter int NUM_CH     = 2,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic [NUM_CH-1:0] req,
   output logic [NUM_CH-1:0] ind
);

   if (ACTIVE_LOW) begin : g_act_low
      assign ind = ~req;
   end else begin : g_act_high
      assign ind = req;
   end

endmodule

// File: rtl/static_run_mute.sv
module static_run_mute
   import amute_pkg::*;
#(
   parameter int SAMPLE_W       = 24,
   parameter int NUM_CH         = 2,
   parameter int RUN_LEN        = 8192,
   parameter bit DETECT_ONES    = 1'b1,
   parameter bit IND_ACTIVE_LOW = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       det_en,
   input  logic                       link_mutes,
   input  logic                       frame_stb,
   input  logic [NUM_CH*SAMPLE_W-1:0] smp_bus,
   output logic [NUM_CH-1:0]          mute_req,
   output logic [NUM_CH-1:0]          mute_ind
);

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("SAMPLE_W must be at least 2");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (RUN_LEN < 2) begin : g_bad_run
      $error("RUN_LEN must be at least 2");
   end

   logic [NUM_CH-1:0] hit;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      smp_class_t cls;

      amute_classify #(
         .SAMPLE_W    (SAMPLE_W),
         .DETECT_ONES (DETECT_ONES)
      ) u_cls (
         .smp (smp_bus[c*SAMPLE_W +: SAMPLE_W]),
         .cls (cls)
      );

      amute_run_cnt #(
         .RUN_LEN (RUN_LEN)
      ) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (det_en),
         .stb     (frame_stb),
         .cls     (cls),
         .run_hit (hit[c])
      );
   end

   amute_link #(
      .NUM_CH (NUM_CH)
   ) u_link (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (det_en),
      .link  (link_mutes),
      .hit   (hit),
      .req   (mute_req)
   );

   amute_ind #(
      .NUM_CH     (NUM_CH),
      .ACTIVE_LOW (IND_ACTIVE_LOW)
   ) u_ind (
      .req (mute_req),
      .ind (mute_ind)
   );

   // Pin and request agree on every channel (R8)
   p_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mute_ind ^ mute_req) == (IND_ACTIVE_LOW ? NUM_CH : 0));
   // Quiet out of reset (R1)
   p_reset_r1: assert property (@(posedge clk)
      !rst_n |-> (mute_req == '0));

endmodule

// File: tb/static_run_mute_tb_top.sv
module static_run_mute_tb_top;

   localparam int SW = 24;
   localparam int NC = 2;
   localparam int RL = 8192;
   localparam logic [SW-1:0] ONES = {SW{1'b1}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic det_en = 1'b0;
   logic link_mutes = 1'b0;
   logic frame_stb = 1'b0;
   logic [NC*SW-1:0] smp_bus = '0;
   logic [NC-1:0] mute_req;
   logic [NC-1:0] mute_ind;

   int n_chk = 0;
   int n_fail = 0;
   int mcnt [NC];
   bit mlast [NC];

   always #10 clk = ~clk;

   static_run_mute #(
      .SAMPLE_W (SW),
      .NUM_CH   (NC),
      .RUN_LEN  (RL)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .det_en     (det_en),
      .link_mutes (link_mutes),
      .frame_stb  (frame_stb),
      .smp_bus    (smp_bus),
      .mute_req   (mute_req),
      .mute_ind   (mute_ind)
   );

   task automatic chk(string req, logic [NC-1:0] act, logic [NC-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   function automatic logic [NC-1:0] exp_req();
      logic [NC-1:0] r;
      for (int c = 0; c < NC; c++) r[c] = (mcnt[c] >= RL);
      if (!det_en) return '0;
      if (link_mutes) return {NC{|r}};
      return r;
   endfunction

   // Drive one cycle at a falling edge, update the model, check at the next one
   task automatic step(bit stb, logic [SW-1:0] a, logic [SW-1:0] b, string req);
      logic [SW-1:0] v;
      bit s;
      bit lv;
      frame_stb = stb;
      smp_bus   = {b, a};
      for (int c = 0; c < NC; c++) begin
         v  = (c == 0) ? a : b;
         s  = (v == '0) || (v == ONES);
         lv = (v == ONES);
         if (!det_en) begin
            mcnt[c] = 0; mlast[c] = 0;
         end else if (stb) begin
            if (!s) mcnt[c] = 0;
            else if (mcnt[c] != 0 && mlast[c] != lv) begin
               mcnt[c] = 1; mlast[c] = lv;
            end else begin
               mlast[c] = lv;
               if (mcnt[c] < RL) mcnt[c]++;
            end
         end
      end
      @(negedge clk);
      chk(req, mute_req, exp_req());
      chk({req, " pin R8"}, mute_ind, ~exp_req());
   endtask

   function automatic logic [SW-1:0] noisy();
      logic [SW-1:0] v = SW'($urandom);
      if (v == '0 || v == ONES) v = 24'h5A5A5A;
      return v;
   endfunction

   function automatic logic [SW-1:0] pick(int mode);
      if (mode == 0) return '0;
      if (mode == 1) return ONES;
      return noisy();
   endfunction

   initial begin
      for (int c = 0; c < NC; c++) begin mcnt[c] = 0; mlast[c] = 0; end
      void'($urandom(1234));
      repeat (3) @(negedge clk);
      chk("R1 reset req", mute_req, 2'b00);
      chk("R1 reset pin", mute_ind, 2'b11);
      rst_n  = 1'b1;
      det_en = 1'b1;
      @(negedge clk);
      chk("R1 after reset", mute_req, 2'b00);

      // R2: exact run boundary on both channels
      repeat (RL - 1) step(1'b1, '0, '0, "R2 run");
      chk("R2 one short", mute_req, 2'b00);
      step(1'b1, '0, '0, "R2 run end");
      chk("R2 run complete", mute_req, 2'b11);
      chk("R8 pins active", mute_ind, 2'b00);

      // R5: saturation keeps the mute
      repeat (300) step(1'b1, '0, '0, "R5 sat");
      chk("R5 still muted", mute_req, 2'b11);

      // R3 and R6: one noisy sample on channel 0 only
      step(1'b1, 24'h000001, '0, "R3 release");
      chk("R3 R6 ch0 released ch1 kept", mute_req, 2'b10);

      // R10: unstrobed noise is ignored
      repeat (6) step(1'b0, 24'h123456, 24'h00F00F, "R10 ignore");
      chk("R10 state kept", mute_req, 2'b10);

      // R7: link takes effect in the same cycle
      link_mutes = 1'b1;
      #1;
      chk("R7 linked req", mute_req, 2'b11);
      chk("R7 linked pin", mute_ind, 2'b00);
      link_mutes = 1'b0;
      #1;
      chk("R7 unlinked", mute_req, 2'b10);
      @(negedge clk);

      // R4: switching level restarts the run
      repeat (RL - 1) step(1'b1, ONES, '0, "R4 ones");
      step(1'b1, '0, '0, "R4 switch");
      repeat (RL - 2) step(1'b1, '0, '0, "R4 zeros");
      chk("R4 restart one short", mute_req, 2'b10);
      step(1'b1, '0, '0, "R4 zeros end");
      chk("R4 restarted run complete", mute_req, 2'b11);

      // R9: disable drops requests at once, then a full run is needed
      det_en = 1'b0;
      #1;
      chk("R9 disable immediate", mute_req, 2'b00);
      chk("R9 disable pins", mute_ind, 2'b11);
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin mcnt[c] = 0; mlast[c] = 0; end
      step(1'b1, '0, '0, "R9 disabled strobe");
      det_en = 1'b1;
      repeat (RL - 1) step(1'b1, ONES, ONES, "R9 rerun");
      chk("R9 rerun one short", mute_req, 2'b00);
      step(1'b1, ONES, ONES, "R9 rerun end");
      chk("R9 rerun complete", mute_req, 2'b11);

      // Random segments against the reference model
      for (int seg = 0; seg < 18; seg++) begin
         int len = $urandom_range(RL + 150, 40);
         int ma  = $urandom_range(2, 0);
         int mb  = $urandom_range(2, 0);
         link_mutes = ($urandom_range(3, 0) == 0);
         for (int i = 0; i < len; i++) begin
            bit sb = ($urandom_range(9, 0) != 0);
            logic [SW-1:0] va = pick(ma);
            logic [SW-1:0] vb = pick(mb);
            if ($urandom_range(2999, 0) == 0) va = noisy();
            step(sb, va, vb, "R2 R3 R6 R7 random");
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule